// File: doc/BRIEF.md
# Flow-Control Calendar Status Extractor

This block rebuilds a per-channel XON/XOFF status vector from the in-band flow-control field of received control words. Each control word carries a group of sixteen calendar entries. A restart flag in the word marks the start of a new calendar pass. The block keeps a write cursor into a 256-entry status register. Each accepted word fills the next sixteen positions, so a calendar of any length, shorter or longer than the register, maps onto the vector by arrival order.

The upstream word decoder supplies a one-cycle strobe together with the sixteen flow-control bits and the restart flag. The integrity and lane-alignment checkers supply two error flags. Either error forces every channel to XOFF. After an error the cursor takes no further writes until a fresh calendar pass starts with a restart word. The status vector is registered and lives in the user-side bus clock domain.

Top module: `fccal_status_extractor`

## Requirements
- R1: After a synchronous active-low reset, all 256 bits of `xon_status` are 0.
- R2: An accepted word with `cw_cal_restart`=1 writes `cw_fc_bits[15]` to status bit 0, `cw_fc_bits[14]` to bit 1, down to `cw_fc_bits[0]` to bit 15, and moves the cursor to position 16.
- R3: An accepted word with `cw_cal_restart`=0 writes its 16 bits to the positions starting at the cursor, with the same ordering (bit 15 of the field lands at the lowest position), and advances the cursor by 16.
- R4: Once 256 entries have been written in the current pass, further words without the restart flag leave the whole vector unchanged.
- R5: Positions that a short calendar pass does not reach keep the values they held before the pass.
- R6: When `crc_err` or `align_lost` is 1 at a clock edge, every status bit is 0 after that edge, and a word presented in the same cycle is not written.
- R7: After reset or after an error clear, words without the restart flag change nothing until a word with the restart flag is accepted.
- R8: With `cw_valid`=0, `cw_fc_bits` and `cw_cal_restart` have no effect on the vector.
- R9: A restart word that arrives in the middle of a pass restarts placement at position 0 and leaves higher positions as they were.
- R10: Each write or clear is visible on `xon_status` immediately after the clock edge that samples the strobe or error flag, and at no earlier time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User-side bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cw_valid | input | 1 | Control-word strobe; the other word fields are sampled only when it is 1 |
| cw_fc_bits | input | 16 | Flow-control entries of the word; bit 15 is the earliest entry |
| cw_cal_restart | input | 1 | Word begins a new calendar pass |
| crc_err | input | 1 | Integrity error reported for the received stream |
| align_lost | input | 1 | Lane alignment lost |
| xon_status | output | 256 | Registered XON(1)/XOFF(0) vector; bit n is calendar position n |

## Verification
Every word, error and idle cycle is driven on a falling edge. The vector is compared one full cycle later, on the next falling edge. That is the first point after the single register stage where a result is due. The bench holds its own model of the cursor and the vector, built from the requirements. It compares all 256 bits after every stimulus, so a write, clear or discard that lands early, late or in the wrong place shows up in that same comparison. The sweep drives calendars of 1 to 20 groups. It runs the long passes first, so the short passes that follow exercise the retention of untouched positions.

// File: rtl/fccal_pkg.sv
// Shared definitions for the flow-control calendar status extractor.
// Assumes: the calendar depth is a whole number of word groups.
package fccal_pkg;

    // Default geometry of the calendar.
    localparam int unsigned FC_ENTRIES_DEF = 256;
    localparam int unsigned FC_GROUP_W_DEF = 16;

    // Cursor phase within one calendar pass.
    typedef enum logic [1:0] {
        CAL_IDLE = 2'd0,  // no pass open: waiting for a restart word
        CAL_FILL = 2'd1,  // pass open and room left in the vector
        CAL_FULL = 2'd2   // vector filled: surplus entries are dropped
    } cal_phase_e;

endpackage

// File: rtl/fccal_cursor.sv
// Write cursor for the calendar status vector.
// Decides, for each cycle, whether a word is written and into which group.
// The cursor counts in whole groups, so the group index is the cursor itself.
// Assumes: clear has priority over any word in the same cycle.
module fccal_cursor
    import fccal_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = 16,
    localparam int unsigned PTR_W = $clog2(NUM_GROUPS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cw_valid,
    input  logic             cal_restart,
    input  logic             clear,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_grp,
    output cal_phase_e       phase
);

    localparam logic [PTR_W-1:0] LAST_GRP = PTR_W'(NUM_GROUPS - 1);
    localparam logic [PTR_W-1:0] END_PTR  = PTR_W'(NUM_GROUPS);
    localparam logic [PTR_W-1:0] ONE_PTR  = PTR_W'(1);

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_d;
    cal_phase_e       phase_q;
    cal_phase_e       phase_d;

    // Select the target group for the current word, if any.
    always_comb begin
        wr_en  = 1'b0;
        wr_grp = '0;
        if (!clear && cw_valid) begin
            if (cal_restart) begin
                wr_en  = 1'b1;
                wr_grp = '0;
            end else if (phase_q == CAL_FILL) begin
                wr_en  = 1'b1;
                wr_grp = ptr_q;
            end
        end
    end

    // Work out the cursor and phase for the next cycle.
    always_comb begin
        ptr_d   = ptr_q;
        phase_d = phase_q;
        if (clear) begin
            ptr_d   = '0;
            phase_d = CAL_IDLE;
        end else if (cw_valid && cal_restart) begin
            ptr_d   = ONE_PTR;
            phase_d = (NUM_GROUPS == 1) ? CAL_FULL : CAL_FILL;
        end else if (cw_valid && phase_q == CAL_FILL) begin
            ptr_d   = ptr_q + ONE_PTR;
            phase_d = (ptr_q == LAST_GRP) ? CAL_FULL : CAL_FILL;
        end
    end

    // Hold cursor state across cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            phase_q <= CAL_IDLE;
        end else begin
            ptr_q   <= ptr_d;
            phase_q <= phase_d;
        end
    end

    assign phase = phase_q;

    AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= END_PTR); // R4

    AST_RESTART_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_valid && cal_restart && !clear) |=> (ptr_q == ONE_PTR)); // R2

    AST_FULL_MEANS_END: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == CAL_FULL) |-> (ptr_q == END_PTR)); // R4

    AST_CLEAR_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (phase_q == CAL_IDLE && ptr_q == '0)); // R7

endmodule

// File: rtl/fccal_group_reg.sv
// One group of calendar status bits.
// Recognises its own index on the shared write bus and stores the word's
// flow-control bits with the earliest entry at the lowest position.
// Assumes: clear and write are never both honoured; clear wins.
module fccal_group_reg #(
    parameter int unsigned GROUP_W = 16,
    parameter int unsigned GRP_IDX = 0,
    parameter int unsigned PTR_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               wr_en,
    input  logic [PTR_W-1:0]   wr_grp,
    input  logic [GROUP_W-1:0] fc_bits,
    output logic [GROUP_W-1:0] q
);

    localparam logic [PTR_W-1:0] MY_IDX = PTR_W'(GRP_IDX);

    logic               sel;
    logic [GROUP_W-1:0] ordered;

    // Decode this group's write select.
    assign sel = wr_en && (wr_grp == MY_IDX);

    // Reverse the field so the earliest entry lands at the lowest bit.
    for (genvar k = 0; k < GROUP_W; k++) begin : g_order
        assign ordered[k] = fc_bits[GROUP_W-1-k];
    end

    // Store, clear or hold the group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clear) begin
            q <= '0;
        end else if (sel) begin
            q <= ordered;
        end
    end

    AST_EARLIEST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !clear) |=> (q[0] == $past(fc_bits[GROUP_W-1]))); // R2

    AST_LATEST_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !clear) |=> (q[GROUP_W-1] == $past(fc_bits[0]))); // R3

    AST_UNSELECTED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !clear) |=> $stable(q)); // R5

endmodule

// File: rtl/fccal_status_extractor.sv
// Flow-control calendar status extractor (top level).
// Rebuilds an XON/XOFF vector from the flow-control groups of received
// control words. A cursor places each group. A restart word reopens the
// pass at position 0. Entries past the end of the vector are dropped, and
// an integrity or alignment error clears the whole vector to XOFF.
// Assumes: all inputs are synchronous to clk (user-side bus clock).
module fccal_status_extractor
    import fccal_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = FC_ENTRIES_DEF,
    parameter int unsigned GROUP_W     = FC_GROUP_W_DEF,
    localparam int unsigned NUM_GROUPS = NUM_ENTRIES / GROUP_W,
    localparam int unsigned PTR_W      = $clog2(NUM_GROUPS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cw_valid,
    input  logic [GROUP_W-1:0]     cw_fc_bits,
    input  logic                   cw_cal_restart,
    input  logic                   crc_err,
    input  logic                   align_lost,
    output logic [NUM_ENTRIES-1:0] xon_status
);

    logic             clear;
    logic             wr_en;
    logic [PTR_W-1:0] wr_grp;
    cal_phase_e       phase;

    // Either link fault forces all channels to XOFF.
    assign clear = crc_err || align_lost;

    // Cursor: decides where each accepted word lands.
    fccal_cursor #(
        .NUM_GROUPS (NUM_GROUPS)
    ) u_cursor (
        .clk         (clk),
        .rst_n       (rst_n),
        .cw_valid    (cw_valid),
        .cal_restart (cw_cal_restart),
        .clear       (clear),
        .wr_en       (wr_en),
        .wr_grp      (wr_grp),
        .phase       (phase)
    );

    // One storage group per word-sized slice of the vector.
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        fccal_group_reg #(
            .GROUP_W (GROUP_W),
            .GRP_IDX (g),
            .PTR_W   (PTR_W)
        ) u_grp (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (clear),
            .wr_en   (wr_en),
            .wr_grp  (wr_grp),
            .fc_bits (cw_fc_bits),
            .q       (xon_status[g*GROUP_W +: GROUP_W])
        );
    end

    initial begin
        AST_WHOLE_GROUPS: assert (NUM_ENTRIES % GROUP_W == 0); // R3
    end

    AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (xon_status == '0)); // R6

    AST_NO_WORD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cw_valid && !clear) |=> $stable(xon_status)); // R8

    AST_SURPLUS_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == CAL_FULL && cw_valid && !cw_cal_restart && !clear)
        |=> $stable(xon_status)); // R4

    AST_IDLE_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == CAL_IDLE && cw_valid && !cw_cal_restart && !clear)
        |=> $stable(xon_status)); // R7

    AST_RESTART_KEEPS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_valid && cw_cal_restart && !clear)
        |=> (xon_status[NUM_ENTRIES-1:GROUP_W] == $past(xon_status[NUM_ENTRIES-1:GROUP_W]))); // R9

endmodule

// File: tb/test_fccal_status_extractor.sv
// Bench for the calendar status extractor: calendar-length sweep, errors,
// idle noise and mid-pass restarts, against an arithmetic model.
module test_fccal_status_extractor;

    localparam int N  = 256;
    localparam int G  = 16;
    localparam int NG = N / G;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cw_valid = 1'b0;
    logic [G-1:0]   cw_fc_bits = '0;
    logic           cw_cal_restart = 1'b0;
    logic           crc_err = 1'b0;
    logic           align_lost = 1'b0;
    logic [N-1:0]   xon_status;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [N-1:0] exp_vec = '0;
    bit           m_open = 1'b0;
    int           m_ptr = 0;

    always #2 clk = ~clk; // 250 MHz

    fccal_status_extractor i_fccal_status_extractor (
        .clk            (clk),
        .rst_n          (rst_n),
        .cw_valid       (cw_valid),
        .cw_fc_bits     (cw_fc_bits),
        .cw_cal_restart (cw_cal_restart),
        .crc_err        (crc_err),
        .align_lost     (align_lost),
        .xon_status     (xon_status)
    );

    task automatic check(input string tag);
        total++;
        if (xon_status !== exp_vec) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, xon_status, exp_vec);
        end
    endtask

    // Model: place one group with the earliest entry at the lowest position.
    task automatic model_word(input logic [G-1:0] fc, input bit rs);
        int base;
        if (rs) begin
            m_open = 1'b1;
            m_ptr  = 0;
        end
        if (m_open && m_ptr < NG) begin
            base = m_ptr * G;
            for (int k = 0; k < G; k++) exp_vec[base + k] = fc[G-1-k];
            m_ptr++;
        end
    endtask

    // Drive one word; the result is due one cycle later (R10).
    task automatic send(input logic [G-1:0] fc, input bit rs, input string tag);
        @(negedge clk);
        cw_valid = 1'b1; cw_fc_bits = fc; cw_cal_restart = rs;
        total++;
        if (xon_status !== exp_vec) begin
            bad++;
            $display("FAIL R10 early change: actual=%h expected=%h", xon_status, exp_vec);
        end
        model_word(fc, rs);
        @(negedge clk);
        cw_valid = 1'b0; cw_cal_restart = 1'b0;
        check(tag);
    endtask

    task automatic fault(input bit crc, input bit aln, input bit with_word, input string tag);
        @(negedge clk);
        crc_err = crc; align_lost = aln;
        cw_valid = with_word; cw_cal_restart = with_word; cw_fc_bits = 16'hFFFF;
        exp_vec = '0; m_open = 1'b0; m_ptr = 0;
        @(negedge clk);
        crc_err = 1'b0; align_lost = 1'b0; cw_valid = 1'b0; cw_cal_restart = 1'b0;
        check(tag);
    endtask

    function automatic logic [G-1:0] pat(input int len, input int i);
        return G'((i * 40503 + len * 4661 + 17) ^ (len << 9));
    endfunction

    initial begin
        int wd = 0;
        while (!finished) begin
            @(posedge clk);
            wd++;
            if (wd > 150000) begin
                bad++; total++;
                $display("FAIL watchdog: actual=hung expected=finished");
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release");

        // Words without restart before any pass are ignored.
        send(16'hFFFF, 1'b0, "R7 no pass after reset");
        send(16'hA5A5, 1'b0, "R7 no pass after reset");

        // Sweep calendar lengths, long first so short passes show retention.
        for (int len = 20; len >= 1; len--) begin
            for (int i = 0; i < len; i++) begin
                if (i == 0) send(pat(len, i), 1'b1, "R2 restart word");
                else if (i >= NG) send(pat(len, i), 1'b0, "R4 surplus dropped");
                else send(pat(len, i), 1'b0, "R3 continuation");
            end
            check("R5 untouched positions kept");
        end

        // Strobe low: field and restart flag are noise.
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            cw_valid = 1'b0; cw_fc_bits = G'(i * 7919); cw_cal_restart = i[0];
            @(negedge clk);
            check("R8 strobe low ignored");
        end
        cw_cal_restart = 1'b0;

        // Mid-pass restart.
        send(16'h1234, 1'b1, "R9 pass start");
        send(16'h5678, 1'b0, "R3 second group");
        send(16'h9ABC, 1'b0, "R3 third group");
        send(16'h0F0F, 1'b1, "R9 restart mid-pass");
        send(16'hC3C3, 1'b0, "R9 continues from position 16");

        // Integrity error with a restart word in the same cycle.
        fault(1'b1, 1'b0, 1'b1, "R6 crc clear beats word");
        send(16'hFFFF, 1'b0, "R7 ignored after clear");
        send(16'h8001, 1'b1, "R2 restart after clear");
        send(16'h7FFE, 1'b0, "R3 after clear");

        // Fill fully, then alignment loss.
        for (int i = 0; i < NG; i++) send(16'hFFFF, (i == 0), "R3 fill all ones");
        send(16'h0000, 1'b0, "R4 full vector kept");
        fault(1'b0, 1'b1, 1'b0, "R6 alignment clear");
        send(16'hFFFF, 1'b0, "R7 ignored after alignment clear");
        fault(1'b1, 1'b1, 1'b0, "R6 both errors");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule